// File: doc/BRIEF.md
# Key-Protected Fractional Bit-Clock Divider

This block makes a serial audio bit clock from one of several input clock sources. The sources arrive as single-cycle tick strobes in the system clock domain. A host programs the block through two 32-bit registers. The control register chooses the source, the dither mode, the run enable and the forced-stop bit. The divisor register holds an integer part and a 12-bit fraction. A write changes a register only when the top byte of the word carries the key value 0x5A. Any other write has no effect.

In integer mode, each output period lasts the clamped integer count of source ticks. In dither mode, a 12-bit phase accumulator adds the fraction once per period. Its carry stretches that period by one tick, so the average period is integer + fraction/4096. Clearing the enable does not stop the output at once. The busy flag stays high until the period in progress has finished, and the output then rests low. Setting the kill bit stops the divider on the next clock. While busy is high, new source or divisor values can be written and read back, but the divider keeps running with the values it started with.

Top module: `fclk_gen`

## Requirements
- R1: A register write whose bits 31:24 differ from 0x5A leaves that register unchanged. This holds for both the control register and the divisor register.
- R2: Control register (wr_sel/rd_sel = 0): bits 3:0 source select, bit 4 enable, bit 5 kill, bit 7 busy, bits 10:9 mode. Divisor register (select = 1): bits 23:12 integer, bits 11:0 fraction. All other read bits are 0.
- R3: In mode 0, every output period lasts exactly max(integer, 2) ticks of the selected source, whatever the fraction is.
- R4: In any nonzero mode, each period lasts either I or I+1 ticks, where I = max(integer, 2). The extra tick comes from the carry of a 12-bit accumulator that adds the fraction once per period, starting from 0, so every run of 8 periods lasts 8·I + (carries) ticks.
- R5: The output is high for the first floor(P/2) ticks of a P-tick period and low for the rest. It is low whenever busy is low.
- R6: An integer value of 0 or 1 behaves as 2.
- R7: Select 0, and any select value of 8 or more, give no ticks. Selects 1 to 7 count only the matching src_tick bit.
- R8: With enable set and kill clear, a stopped divider starts on the next clock. busy rises and the output goes high together.
- R9: After enable is cleared, busy stays high until the current period has ended on a source tick. Then busy and the output fall together.
- R10: While kill is set, the divider stops on the next clock with the output low, and it cannot start.
- R11: While busy is high, new source, integer, fraction and mode values are stored and read back, but they do not take effect until the divider has stopped.
- R12: Writes to the busy bit have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write word; bits 31:24 carry the key |
| rd_sel | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Read word of the selected register |
| src_tick | input | NUM_SRC-1 (7) | Tick strobes of sources 1..NUM_SRC-1 |
| busy | output | 1 | Divider running |
| clk_out | output | 1 | Divided bit clock |

## Verification
The bench uses the default parameters: eight sources, a 12-bit integer, a 12-bit fraction and the dither variant built in. With a 12-bit fraction, the values 0x800 and 0x400 make the carry pattern repeat every two and four periods, so exact tick totals over eight periods can be predicted. The wide integer field still lets the values 0 and 1 reach the clamp. Source 1 ticks every cycle and source 2 every third cycle, so the measured periods show whether the source mux counts only the selected strobe. Source 0 gives a divider that never reaches a period boundary, so the only way out is the forced stop.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
   localparam int REG_W    = 32;
   localparam int KEY_LSB  = 24;
   localparam int SRC_W    = 4;
   localparam int EN_BIT   = 4;
   localparam int KILL_BIT = 5;
   localparam int BUSY_BIT = 7;
   localparam int MODE_LSB = 9;
   localparam int MODE_W   = 2;

   typedef enum logic {
      SEL_CTL = 1'b0,
      SEL_DIV = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic [MODE_W-1:0] mode;
      logic              kill;
      logic              en;
      logic [SRC_W-1:0]  src;
   } ctl_t;
endpackage

// File: rtl/fcg_regs.sv
module fcg_regs
   import fcg_pkg::*;
#(
   parameter int         INT_W  = 12,
   parameter int         FRAC_W = 12,
   parameter logic [7:0] KEY    = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_sel,
   input  logic              busy,
   output ctl_t              ctl_q,
   output logic [INT_W-1:0]  int_q,
   output logic [FRAC_W-1:0] frac_q,
   output logic [REG_W-1:0]  rd_data
);
   logic key_ok;
   logic unused_wr;

   assign key_ok    = (wr_data[KEY_LSB +: 8] == KEY);
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         int_q  <= '0;
         frac_q <= '0;
      end else if (wr_en && key_ok) begin
         if (wr_sel == SEL_DIV) begin
            int_q  <= wr_data[FRAC_W +: INT_W];
            frac_q <= wr_data[FRAC_W-1:0];
         end else begin
            ctl_q.src  <= wr_data[SRC_W-1:0];
            ctl_q.en   <= wr_data[EN_BIT];
            ctl_q.kill <= wr_data[KILL_BIT];
            ctl_q.mode <= wr_data[MODE_LSB +: MODE_W];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_sel == SEL_DIV) begin
         rd_data[FRAC_W +: INT_W] = int_q;
         rd_data[FRAC_W-1:0]      = frac_q;
      end else begin
         rd_data[SRC_W-1:0]          = ctl_q.src;
         rd_data[EN_BIT]             = ctl_q.en;
         rd_data[KILL_BIT]           = ctl_q.kill;
         rd_data[BUSY_BIT]           = busy;
         rd_data[MODE_LSB +: MODE_W] = ctl_q.mode;
      end
   end
endmodule

// File: rtl/fcg_src_mux.sv
module fcg_src_mux #(
   parameter int NUM_SRC = 8,
   parameter int SEL_W   = 4
) (
   input  logic [NUM_SRC-1:1] src_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   logic [NUM_SRC-1:1] hit;

   for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
      localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
      assign hit[i] = (sel == IDX) & src_tick[i];
   end

   assign tick = |hit;
endmodule

// File: rtl/fcg_divider.sv
module fcg_divider
   import fcg_pkg::*;
#(
   parameter int INT_W  = 12,
   parameter int FRAC_W = 12,
   parameter bit DITHER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl_q,
   input  logic [INT_W-1:0]  int_q,
   input  logic [FRAC_W-1:0] frac_q,
   input  logic              tick,
   output logic [SRC_W-1:0]  use_src,
   output logic              busy,
   output logic              clk_out,
   output logic              period_end
);
   localparam int              CNT_W   = INT_W + 1;
   localparam logic [CNT_W-1:0] MIN_DIV = CNT_W'(2);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic              run_q, out_q;
   logic [CNT_W-1:0]  cnt_q, per_q;
   logic [SRC_W-1:0]  a_src;
   logic [INT_W-1:0]  a_int, u_int;
   logic [FRAC_W-1:0] a_frac, u_frac;
   logic [MODE_W-1:0] a_mode, u_mode;
   logic [CNT_W-1:0]  int_eff, new_per, cnt_inc;
   logic              carry, dith_on, load_per, acc_clr, start, stop_now;

   // frozen while running, transparent while stopped
   assign use_src = run_q ? a_src  : ctl_q.src;
   assign u_int   = run_q ? a_int  : int_q;
   assign u_frac  = run_q ? a_frac : frac_q;
   assign u_mode  = run_q ? a_mode : ctl_q.mode;

   assign dith_on    = (u_mode != '0);
   assign int_eff    = (u_int < INT_W'(2)) ? MIN_DIV : {1'b0, u_int};
   assign new_per    = int_eff + {{INT_W{1'b0}}, carry};
   assign cnt_inc    = cnt_q + ONE;
   assign period_end = run_q && tick && (cnt_q == per_q - ONE);

   assign start    = !ctl_q.kill && !run_q && ctl_q.en;
   assign stop_now = !ctl_q.kill && period_end && !ctl_q.en;
   assign load_per = start || (!ctl_q.kill && period_end && ctl_q.en);
   assign acc_clr  = ctl_q.kill || stop_now;

   if (DITHER) begin : g_dither
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W:0]   sum;
      assign sum   = {1'b0, acc_q} + {1'b0, u_frac};
      assign carry = dith_on & sum[FRAC_W];
      always_ff @(posedge clk) begin
         if (!rst_n)                  acc_q <= '0;
         else if (acc_clr)            acc_q <= '0;
         else if (load_per && dith_on) acc_q <= sum[FRAC_W-1:0];
      end
   end else begin : g_plain
      logic unused_frac;
      assign carry       = 1'b0;
      assign unused_frac = ^{u_frac, dith_on};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_src  <= '0;
         a_int  <= '0;
         a_frac <= '0;
         a_mode <= '0;
      end else begin
         a_src  <= use_src;
         a_int  <= u_int;
         a_frac <= u_frac;
         a_mode <= u_mode;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         out_q <= 1'b0;
         cnt_q <= '0;
         per_q <= MIN_DIV;
      end else if (ctl_q.kill) begin
         run_q <= 1'b0;
         out_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_per) begin
         run_q <= 1'b1;
         out_q <= 1'b1;
         cnt_q <= '0;
         per_q <= new_per;
      end else if (stop_now) begin
         run_q <= 1'b0;
         out_q <= 1'b0;
         cnt_q <= '0;
      end else if (run_q && tick) begin
         cnt_q <= cnt_inc;
         out_q <= (cnt_inc < (per_q >> 1));
      end
   end

   assign busy    = run_q;
   assign clk_out = out_q;
endmodule

// File: rtl/fclk_gen.sv
module fclk_gen
   import fcg_pkg::*;
#(
   parameter int         NUM_SRC = 8,
   parameter int         INT_W   = 12,
   parameter int         FRAC_W  = 12,
   parameter logic [7:0] KEY     = 8'h5A,
   parameter bit         DITHER  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               rd_sel,
   output logic [REG_W-1:0]   rd_data,
   input  logic [NUM_SRC-1:1] src_tick,
   output logic               busy,
   output logic               clk_out
);
   if (INT_W + FRAC_W > KEY_LSB) begin : g_bad_width
      $error("divisor fields overlap the key byte");
   end
   if (NUM_SRC < 2 || NUM_SRC > (1 << SRC_W)) begin : g_bad_src
      $error("NUM_SRC out of range for the select field");
   end
   if (FRAC_W < 1 || INT_W < 2) begin : g_bad_frac
      $error("divisor field widths too small");
   end

   ctl_t              ctl_q;
   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   logic [SRC_W-1:0]  use_src;
   logic              tick;
   logic              period_end;

   fcg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .busy(busy),
      .ctl_q(ctl_q), .int_q(int_q), .frac_q(frac_q), .rd_data(rd_data)
   );

   fcg_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SRC_W)) u_mux (
      .src_tick(src_tick), .sel(use_src), .tick(tick)
   );

   fcg_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DITHER(DITHER)) u_div (
      .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .int_q(int_q),
      .frac_q(frac_q), .tick(tick), .use_src(use_src), .busy(busy),
      .clk_out(clk_out), .period_end(period_end)
   );
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
   parameter int         INT_W  = 12,
   parameter int         FRAC_W = 12,
   parameter logic [7:0] KEY    = 8'h5A
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    wr_sel,
   input logic [7:0]              wr_key,
   input logic                    en_bit,
   input logic                    kill_bit,
   input logic [INT_W+FRAC_W-1:0] div_word,
   input logic                    busy,
   input logic                    clk_out,
   input logic                    period_end,
   input logic                    tick,
   input logic [3:0]              use_src
);
   p_bad_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_key != KEY) |=> $stable(div_word));

   p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !clk_out);

   p_ground_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (use_src == 4'd0) |-> !tick);

   p_start_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en_bit));

   p_graceful_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !kill_bit && !period_end) |=> busy);

   p_kill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      kill_bit |=> (!busy && !clk_out));

   p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(use_src));
endmodule

bind fclk_gen fcg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W), .KEY(KEY)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_key(wr_data[31:24]), .en_bit(ctl_q.en), .kill_bit(ctl_q.kill),
   .div_word({int_q, frac_q}), .busy(busy), .clk_out(clk_out),
   .period_end(period_end), .tick(tick), .use_src(use_src)
);

// File: tb/fclk_gen_tb.sv
module fclk_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [7:1]  src_tick = '0;
   logic        busy, clk_out;

   int checks = 0, errs = 0;
   string cur_req = "R2";

   fclk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .src_tick(src_tick), .busy(busy), .clk_out(clk_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // source strobes: 1 every cycle, 2 every third cycle, rest pseudo-random
   int         div3 = 0;
   logic [7:0] lfsr = 8'h01;
   always @(posedge clk) begin
      #2;
      div3 = (div3 == 2) ? 0 : div3 + 1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      src_tick = {lfsr[4:0], (div3 == 0), 1'b1};
   end

   // behavioural reference model
   int m_src, m_en, m_kill, m_mode, m_int, m_frac;
   int a_src, a_int, a_frac, a_mode;
   int m_run, m_cnt, m_per, m_acc, m_out;
   int u_src, u_int, u_frac, u_mode, ieff, tk, sum, np;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_src = 0; m_en = 0; m_kill = 0; m_mode = 0; m_int = 0; m_frac = 0;
         a_src = 0; a_int = 0; a_frac = 0; a_mode = 0;
         m_run = 0; m_cnt = 0; m_per = 2; m_acc = 0; m_out = 0;
      end else begin
         u_src  = m_run ? a_src  : m_src;
         u_int  = m_run ? a_int  : m_int;
         u_frac = m_run ? a_frac : m_frac;
         u_mode = m_run ? a_mode : m_mode;
         a_src = u_src; a_int = u_int; a_frac = u_frac; a_mode = u_mode;
         ieff = (u_int < 2) ? 2 : u_int;
         tk   = (u_src >= 1 && u_src <= 7) ? int'(src_tick[u_src]) : 0;
         sum  = m_acc + u_frac;
         np   = ieff + ((u_mode != 0 && sum >= 4096) ? 1 : 0);
         if (m_kill != 0) begin
            m_run = 0; m_cnt = 0; m_acc = 0; m_out = 0;
         end else if (m_run == 0) begin
            if (m_en != 0) begin
               m_run = 1; m_cnt = 0; m_per = np; m_out = 1;
               if (u_mode != 0) m_acc = sum % 4096;
            end
         end else if (tk != 0 && m_cnt == m_per - 1) begin
            if (m_en == 0) begin
               m_run = 0; m_cnt = 0; m_acc = 0; m_out = 0;
            end else begin
               m_cnt = 0; m_per = np; m_out = 1;
               if (u_mode != 0) m_acc = sum % 4096;
            end
         end else if (tk != 0) begin
            m_cnt = m_cnt + 1;
            m_out = (m_cnt < m_per / 2) ? 1 : 0;
         end
         if (wr_en && wr_data[31:24] == 8'h5A) begin
            if (wr_sel) begin
               m_int = int'(wr_data[23:12]); m_frac = int'(wr_data[11:0]);
            end else begin
               m_src = int'(wr_data[3:0]); m_en = int'(wr_data[4]);
               m_kill = int'(wr_data[5]); m_mode = int'(wr_data[10:9]);
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // compare against the model on every clock
   logic [31:0] exp_rd;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_sel)
            exp_rd = 32'(m_int << 12) | 32'(m_frac);
         else
            exp_rd = 32'(m_mode << 9) | 32'(m_run << 7) | 32'(m_kill << 5)
                   | 32'(m_en << 4) | 32'(m_src);
         chk(cur_req, "model clk_out", {31'b0, clk_out}, 32'(m_out));
         chk(cur_req, "model busy", {31'b0, busy}, 32'(m_run));
         chk(cur_req, "model rd_data", rd_data, exp_rd);
      end
   end

   function automatic logic [31:0] ctl_w(int src, int en, int kill, int mode);
      return 32'h5A00_0000 | 32'(mode << 9) | 32'(kill << 5) | 32'(en << 4) | 32'(src);
   endfunction

   function automatic logic [31:0] div_w(int ip, int fp);
      return 32'h5A00_0000 | 32'(ip << 12) | 32'(fp);
   endfunction

   task automatic wr(input logic sel, input logic [31:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // measure n consecutive output periods (samples at negedge)
   task automatic periods(input int n, output int total, output int pmin,
                          output int pmax, output int hi_last);
      int prev, guard, per, hi;
      logic found;
      prev = clk_out; guard = 0; found = 0;
      total = 0; pmin = 1 << 30; pmax = 0; hi_last = 0;
      while (!found && guard < 1000) begin
         @(negedge clk); guard++;
         if (prev == 0 && clk_out == 1) found = 1;
         prev = clk_out;
      end
      for (int k = 0; k < n; k++) begin
         per = 0; hi = 0; found = 0;
         while (!found && guard < 4000) begin
            hi += int'(clk_out); per++;
            @(negedge clk); guard++;
            if (prev == 0 && clk_out == 1) found = 1;
            prev = clk_out;
         end
         total += per; hi_last = hi;
         if (per < pmin) pmin = per;
         if (per > pmax) pmax = per;
      end
   endtask

   task automatic stop_wait(input int src);
      int g;
      wr(1'b0, ctl_w(src, 0, 0, 0));
      g = 0;
      while (busy && g < 200) begin @(negedge clk); g++; end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      int tot, pmn, pmx, hi;
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R8", "reset busy", {31'b0, busy}, 32'd0);
      chk("R5", "reset clk_out", {31'b0, clk_out}, 32'd0);
      chk("R2", "reset ctl read", rd_data, 32'd0);

      // mode 0, integer 5, fraction ignored
      cur_req = "R3";
      wr(1'b1, div_w(5, 12'h123));
      wr(1'b0, ctl_w(1, 1, 0, 0));
      periods(4, tot, pmn, pmx, hi);
      chk("R3", "mode0 min period", 32'(pmn), 32'd5);
      chk("R3", "mode0 max period", 32'(pmx), 32'd5);
      chk("R5", "high phase of 5", 32'(hi), 32'd2);

      // graceful stop
      cur_req = "R9";
      wr(1'b0, ctl_w(1, 0, 0, 0));
      @(negedge clk);
      chk("R9", "busy held after disable", {31'b0, busy}, 32'd1);
      cycles(8);
      chk("R9", "stopped after boundary", {31'b0, busy}, 32'd0);
      chk("R5", "low when stopped", {31'b0, clk_out}, 32'd0);

      // clamp of small integers
      cur_req = "R6";
      wr(1'b1, div_w(1, 0));
      wr(1'b0, ctl_w(1, 1, 0, 0));
      periods(3, tot, pmn, pmx, hi);
      chk("R6", "integer 1 period", 32'(pmx), 32'd2);
      chk("R5", "high phase of 2", 32'(hi), 32'd1);
      stop_wait(1);
      wr(1'b1, div_w(0, 0));
      wr(1'b0, ctl_w(1, 1, 0, 0));
      periods(3, tot, pmn, pmx, hi);
      chk("R6", "integer 0 period", 32'(pmn), 32'd2);
      stop_wait(1);

      // first-order dither
      cur_req = "R4";
      wr(1'b1, div_w(4, 12'h800));
      wr(1'b0, ctl_w(1, 1, 0, 1));
      periods(8, tot, pmn, pmx, hi);
      chk("R4", "half fraction total", 32'(tot), 32'd36);
      chk("R4", "half fraction min", 32'(pmn), 32'd4);
      chk("R4", "half fraction max", 32'(pmx), 32'd5);
      stop_wait(1);
      wr(1'b1, div_w(4, 12'h400));
      wr(1'b0, ctl_w(1, 1, 0, 1));
      periods(8, tot, pmn, pmx, hi);
      chk("R4", "quarter fraction total", 32'(tot), 32'd34);
      stop_wait(1);

      // changes while busy are held back
      cur_req = "R11";
      wr(1'b1, div_w(6, 0));
      wr(1'b0, ctl_w(1, 1, 0, 0));
      cycles(3);
      wr(1'b1, div_w(9, 0));
      rd_sel = 1'b1;
      @(negedge clk);
      chk("R11", "new divisor reads back", rd_data, 32'h0000_9000);
      periods(3, tot, pmn, pmx, hi);
      chk("R11", "old period kept while busy", 32'(pmx), 32'd6);
      stop_wait(1);
      wr(1'b0, ctl_w(1, 1, 0, 0));
      periods(2, tot, pmn, pmx, hi);
      chk("R11", "new period after restart", 32'(pmn), 32'd9);
      stop_wait(1);

      // key check
      cur_req = "R1";
      wr(1'b1, 32'hA500_3000);
      @(negedge clk);
      chk("R1", "divisor kept on bad key", rd_data, 32'h0000_9000);
      rd_sel = 1'b0;
      wr(1'b0, 32'h0000_0011);
      cycles(4);
      chk("R1", "control kept on bad key", rd_data, 32'h0000_0001);
      chk("R1", "no start on bad key", {31'b0, busy}, 32'd0);

      // busy bit is read-only
      cur_req = "R12";
      wr(1'b0, ctl_w(2, 0, 0, 0) | 32'h80);
      cycles(3);
      chk("R12", "busy write ignored", rd_data, 32'h0000_0002);
      chk("R2", "ctl field layout", {31'b0, busy}, 32'd0);

      // ground source, stuck run, kill
      cur_req = "R7";
      wr(1'b0, ctl_w(0, 1, 0, 0));
      cycles(2);
      chk("R8", "busy after enable", {31'b0, busy}, 32'd1);
      cycles(20);
      chk("R7", "ground source never ticks", {31'b0, clk_out}, 32'd1);
      cur_req = "R9";
      wr(1'b0, ctl_w(0, 0, 0, 0));
      cycles(10);
      chk("R9", "busy held without boundary", {31'b0, busy}, 32'd1);
      cur_req = "R10";
      wr(1'b0, ctl_w(0, 1, 1, 0));
      @(negedge clk);
      @(negedge clk);
      chk("R10", "kill stops busy", {31'b0, busy}, 32'd0);
      chk("R10", "kill forces low", {31'b0, clk_out}, 32'd0);
      cycles(5);
      chk("R10", "no start while kill", {31'b0, busy}, 32'd0);
      wr(1'b0, ctl_w(0, 0, 0, 0));

      // only the selected source counts
      cur_req = "R7";
      wr(1'b1, div_w(2, 0));
      wr(1'b0, ctl_w(2, 1, 0, 0));
      periods(3, tot, pmn, pmx, hi);
      chk("R7", "every third cycle source", 32'(pmx), 32'd6);
      chk("R7", "every third cycle high", 32'(hi), 32'd3);
      stop_wait(2);

      cycles(3);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end
endmodule